// File: doc/BRIEF.md
# Presence-Bit Deferred-Read Memory

This block is a write-once memory for shared data structures. Each word holds a value and a presence bit that marks it empty or full. A read of a full word returns the stored value to the tag that came with the request. A read of an empty word gets no reply straight away. The memory records the requester's return tag against that word instead.

When a store later fills the word, the memory forwards the new value to every recorded tag, one per cycle, in the order the reads arrived. While these deferred replies drain, the request port stalls. A word is used in four steps: it starts empty, receives one value, serves any number of reads, and is then freed on purpose so that it can be reused. A second store to a full word is refused with an error pulse. A free is refused while reads are still waiting on the word.

Requests arrive on a single valid/ready port that carries an operation, an address, data and a tag. Replies leave on a tag/data port with a valid strobe. There is no backpressure on the reply side.

Top module: `deferred_read_mem`

## Requirements
- R1: After synchronous active-low reset, every word is empty and no reads are pending. `rsp_valid`, `store_err` and `free_err` are 0, and `req_ready` is 1 for any request that is not a read.
- R2: A read (`req_op`=0) accepted on a full word produces `rsp_valid`=1 one cycle after the accepting edge, with `rsp_tag` equal to the request tag and `rsp_data` equal to the stored value.
- R3: A read accepted on an empty word produces no response. Its tag is recorded against that word.
- R4: A store (`req_op`=1) accepted on an empty word writes the value and marks the word full. If k reads are pending on it, k responses follow on the k cycles after the accepting edge. They carry the stored value and the pending tags in arrival order. The pending list of that word is then empty.
- R5: A word holds at most 4 pending reads. While a read to an empty word that already has 4 pending reads is presented, `req_ready` is 0.
- R6: From the cycle after a store that has pending reads up to and including the cycle that presents the last deferred response, `req_ready` is 0 and no request is accepted.
- R7: A store accepted on a full word pulses `store_err` for one cycle, one cycle after the accepting edge. The stored value is unchanged and no response is produced.
- R8: A free (`req_op`=2) accepted on a word with no pending reads makes the word empty. A later read of that word is deferred.
- R9: A free accepted on a word with pending reads pulses `free_err` one cycle after the accepting edge. It changes neither the word nor its pending reads, so a later store still answers them.
- R10: A request with `req_op`=3 is accepted and has no effect on any word, pending list or output.
- R11: A store accepted on an empty word with no pending reads produces no response and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 0 read, 1 store, 2 free, 3 no operation |
| req_addr | input | ADDR_W (6) | Word address |
| req_data | input | DATA_W (16) | Store value |
| req_tag | input | TAG_W (8) | Return tag for a read |
| rsp_valid | output | 1 | Response strobe |
| rsp_tag | output | TAG_W (8) | Destination tag of the response |
| rsp_data | output | DATA_W (16) | Value returned |
| store_err | output | 1 | Store to a full word was refused |
| free_err | output | 1 | Free refused because reads are pending |

## Verification
`req_ready` is combinational, so its result is due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples `req_ready` shortly afterwards, before the next rising edge. A hit response and both error pulses are registered once, so they are due one cycle after the accepting edge. The k deferred responses of a store are due on the k edges that follow it. The behavioural reference model advances once per rising edge and predicts the output that edge will register. The bench compares every output with that prediction at the next falling edge. Each compare is therefore taken exactly one register stage after the request it belongs to.

// File: rtl/drm_pkg.sv
// Package: operation codes shared by the deferred-read memory and its bench.
// Assumes a two-bit operation field on the request port.
package drm_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_STORE = 2'd1,
        OP_FREE  = 2'd2,
        OP_NOP   = 2'd3
    } op_e;
endpackage

// File: rtl/drm_word_store.sv
// Module: value storage plus the presence bit of every word.
// Provides a lookup port for the request address and a second read port
// for the word being drained. Assumes set and clear never hit in one cycle.
module drm_word_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_full,
    input  logic              clr_full,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_full,
    output logic [DATA_W-1:0] lk_data,
    input  logic [ADDR_W-1:0] dr_addr,
    output logic [DATA_W-1:0] dr_data
);
    logic [DEPTH-1:0]  full_q;
    logic [DATA_W-1:0] mem [DEPTH];

    // Presence bits: reset to empty, set by a store, cleared by a free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
        end else begin
            if (set_full) full_q[wr_addr] <= 1'b1;
            if (clr_full) full_q[wr_addr] <= 1'b0;
        end
    end

    // Value array: written only when an empty word is filled.
    always_ff @(posedge clk) begin
        if (set_full) mem[wr_addr] <= wr_data;
    end

    // Read ports for the request lookup and the drain sequencer.
    assign lk_full = full_q[lk_addr];
    assign lk_data = mem[lk_addr];
    assign dr_data = mem[dr_addr];

    // A full word is never written again (value is kept).
    assert_keep_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_full |-> !full_q[wr_addr]);
    assert_set_clr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_full && clr_full));
endmodule

// File: rtl/drm_defer_queue.sv
// Module: per-word list of pending read tags with a fill count.
// Tags are appended in arrival order and read back by index while a
// store drains them. Assumes push and clear never occur in one cycle.
module drm_defer_queue #(
    parameter int DEPTH     = 64,
    parameter int TAG_W     = 8,
    parameter int MAX_DEFER = 4,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(MAX_DEFER + 1),
    localparam int IDX_W  = $clog2(MAX_DEFER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              clr,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [CNT_W-1:0]  lk_cnt,
    input  logic [ADDR_W-1:0] dr_addr,
    input  logic [IDX_W-1:0]  dr_idx,
    output logic [TAG_W-1:0]  dr_tag
);
    logic [TAG_W-1:0] tags [DEPTH][MAX_DEFER];
    logic [CNT_W-1:0] cnt  [DEPTH];

    // Fill counts: reset to zero, bumped by a deferred read, zeroed after a drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cnt[i] <= '0;
        end else if (push) begin
            cnt[push_addr] <= cnt[push_addr] + CNT_W'(1);
        end else if (clr) begin
            cnt[clr_addr] <= '0;
        end
    end

    // Tag slots: the next free slot of the word takes the new tag.
    always_ff @(posedge clk) begin
        if (push) tags[push_addr][cnt[push_addr][IDX_W-1:0]] <= push_tag;
    end

    // Lookup of the pending count and of the tag being drained.
    assign lk_cnt = cnt[lk_addr];
    assign dr_tag = tags[dr_addr][dr_idx];

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt[push_addr] < CNT_W'(MAX_DEFER)));
    assert_push_clr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && clr));
endmodule

// File: rtl/drm_drain_ctrl.sv
// Module: response sequencer and response register.
// Either forwards an immediate hit or walks the pending tags of one word,
// one per cycle. Assumes start only arrives while idle.
module drm_drain_ctrl #(
    parameter int DEPTH     = 64,
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 8,
    parameter int MAX_DEFER = 4,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(MAX_DEFER + 1),
    localparam int IDX_W  = $clog2(MAX_DEFER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              imm_valid,
    input  logic [TAG_W-1:0]  imm_tag,
    input  logic [DATA_W-1:0] imm_data,
    input  logic [TAG_W-1:0]  dr_tag,
    input  logic [DATA_W-1:0] dr_data,
    output logic              busy,
    output logic [ADDR_W-1:0] dr_addr,
    output logic [IDX_W-1:0]  dr_idx,
    output logic              done,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data
);
    logic [IDX_W-1:0] last_q;

    // The last pending tag of the word is presented this cycle.
    assign done = busy && (dr_idx == last_q);

    // Sequencer and response register: drain first, then immediate hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            dr_addr   <= '0;
            dr_idx    <= '0;
            last_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_tag   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (busy) begin
                rsp_valid <= 1'b1;
                rsp_tag   <= dr_tag;
                rsp_data  <= dr_data;
                if (done) busy <= 1'b0;
                else      dr_idx <= dr_idx + IDX_W'(1);
            end else if (start) begin
                busy    <= 1'b1;
                dr_addr <= start_addr;
                dr_idx  <= '0;
                last_q  <= IDX_W'(start_cnt - CNT_W'(1));
            end else if (imm_valid) begin
                rsp_valid <= 1'b1;
                rsp_tag   <= imm_tag;
                rsp_data  <= imm_data;
            end
        end
    end

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    assert_drain_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && (dr_idx == IDX_W'($past(dr_idx) + IDX_W'(1)))));
    assert_drain_emits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> rsp_valid);
endmodule

// File: rtl/deferred_read_mem.sv
// Module: top of the presence-bit memory with deferred reads.
// Decodes requests, steers stores, frees and reads to the word store and
// the pending-tag lists, and stalls the port while a drain runs or a
// pending list is full. Assumes the response side never backpressures.
module deferred_read_mem
    import drm_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 8,
    parameter int MAX_DEFER = 4,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(MAX_DEFER + 1),
    localparam int IDX_W  = $clog2(MAX_DEFER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              store_err,
    output logic              free_err
);
    op_e               op;
    logic              accept;
    logic              lk_full;
    logic [DATA_W-1:0] lk_data;
    logic [CNT_W-1:0]  lk_cnt;
    logic              busy;
    logic              done;
    logic [ADDR_W-1:0] dr_addr;
    logic [IDX_W-1:0]  dr_idx;
    logic [TAG_W-1:0]  dr_tag;
    logic [DATA_W-1:0] dr_data;
    logic              do_fill;
    logic              do_defer;
    logic              do_free;
    logic              do_hit;

    // Request decode and port stall.
    always_comb begin
        op        = op_e'(req_op);
        req_ready = !busy && !((op == OP_READ) && !lk_full &&
                               (lk_cnt == CNT_W'(MAX_DEFER)));
        accept    = req_valid && req_ready;
        do_hit    = accept && (op == OP_READ)  && lk_full;
        do_defer  = accept && (op == OP_READ)  && !lk_full;
        do_fill   = accept && (op == OP_STORE) && !lk_full;
        do_free   = accept && (op == OP_FREE)  && (lk_cnt == '0);
    end

    // Error pulses for refused stores and refused frees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_err <= 1'b0;
            free_err  <= 1'b0;
        end else begin
            store_err <= accept && (op == OP_STORE) && lk_full;
            free_err  <= accept && (op == OP_FREE) && (lk_cnt != '0);
        end
    end

    drm_word_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_full (do_fill),
        .clr_full (do_free),
        .wr_addr  (req_addr),
        .wr_data  (req_data),
        .lk_addr  (req_addr),
        .lk_full  (lk_full),
        .lk_data  (lk_data),
        .dr_addr  (dr_addr),
        .dr_data  (dr_data)
    );

    drm_defer_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .MAX_DEFER(MAX_DEFER)) i_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_defer),
        .push_addr (req_addr),
        .push_tag  (req_tag),
        .clr       (done),
        .clr_addr  (dr_addr),
        .lk_addr   (req_addr),
        .lk_cnt    (lk_cnt),
        .dr_addr   (dr_addr),
        .dr_idx    (dr_idx),
        .dr_tag    (dr_tag)
    );

    drm_drain_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W),
                     .MAX_DEFER(MAX_DEFER)) i_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (do_fill && (lk_cnt != '0)),
        .start_addr (req_addr),
        .start_cnt  (lk_cnt),
        .imm_valid  (do_hit),
        .imm_tag    (req_tag),
        .imm_data   (lk_data),
        .dr_tag     (dr_tag),
        .dr_data    (dr_data),
        .busy       (busy),
        .dr_addr    (dr_addr),
        .dr_idx     (dr_idx),
        .done       (done),
        .rsp_valid  (rsp_valid),
        .rsp_tag    (rsp_tag),
        .rsp_data   (rsp_data)
    );

    assert_hit_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_hit |=> (rsp_valid && (rsp_tag == $past(req_tag))));
    assert_refused_store_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store_err |-> !rsp_valid);
    assert_refused_free_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        free_err |-> !rsp_valid);
    assert_defer_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_defer && !busy) |=> !rsp_valid);
endmodule

// File: tb/test_deferred_read_mem.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (arrays and queues) advanced once per
// clock and compared with every output at the following falling edge.
module test_deferred_read_mem;
    localparam int DEPTH  = 64;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 8;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd3;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              rsp_valid;
    logic [TAG_W-1:0]  rsp_tag;
    logic [DATA_W-1:0] rsp_data;
    logic              store_err;
    logic              free_err;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state.
    bit    m_full [DEPTH];
    int    m_data [DEPTH];
    int    m_pend [DEPTH][$];
    int    dq_tag [$];
    int    dq_data [$];
    bit    e_valid = 0;
    int    e_tag = 0;
    int    e_data = 0;
    bit    e_serr = 0;
    bit    e_ferr = 0;
    string e_lbl = "R1";

    always #5 clk = ~clk;

    deferred_read_mem i_deferred_read_mem (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .store_err(store_err), .free_err(free_err)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    function automatic bit model_ready(input int op, input int a);
        if (dq_tag.size() != 0) return 0;
        if (op == 0 && !m_full[a] && m_pend[a].size() == 4) return 0;
        return 1;
    endfunction

    // One clock: compare last edge's outputs, drive, check ready, advance model.
    task automatic step(input bit v, input int op, input int a, input int d,
                        input int t, input string lbl);
        bit rdy;
        @(negedge clk);
        chk(e_lbl, "rsp_valid", int'(rsp_valid), int'(e_valid));
        if (e_valid) begin
            chk(e_lbl, "rsp_tag", int'(rsp_tag), e_tag);
            chk(e_lbl, "rsp_data", int'(rsp_data), e_data);
        end
        chk(e_lbl, "store_err", int'(store_err), int'(e_serr));
        chk(e_lbl, "free_err", int'(free_err), int'(e_ferr));
        req_valid = v;
        req_op    = op[1:0];
        req_addr  = a[ADDR_W-1:0];
        req_data  = d[DATA_W-1:0];
        req_tag   = t[TAG_W-1:0];
        #1;
        rdy = model_ready(op, a);
        chk(lbl, "req_ready", int'(req_ready), int'(rdy));
        e_valid = 0; e_serr = 0; e_ferr = 0; e_lbl = lbl;
        if (dq_tag.size() != 0) begin
            e_valid = 1;
            e_tag   = dq_tag.pop_front();
            e_data  = dq_data.pop_front();
            e_lbl   = "R4";
        end else if (v && rdy) begin
            case (op)
                0: if (m_full[a]) begin
                       e_valid = 1; e_tag = t; e_data = m_data[a];
                   end else begin
                       m_pend[a].push_back(t);
                   end
                1: if (m_full[a]) begin
                       e_serr = 1;
                   end else begin
                       m_full[a] = 1;
                       m_data[a] = d;
                       for (int i = 0; i < m_pend[a].size(); i++) begin
                           dq_tag.push_back(m_pend[a][i]);
                           dq_data.push_back(d);
                       end
                       m_pend[a].delete();
                   end
                2: if (m_pend[a].size() != 0) e_ferr = 1;
                   else m_full[a] = 0;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int n, input string lbl);
        for (int i = 0; i < n; i++) step(0, 3, 0, 0, 0, lbl);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, ready for a store on every word.
        step(0, 1, 0, 0, 0, "R1");
        idle(1, "R1");
        // R3: reads of an empty word are deferred.
        step(1, 0, 5, 0, 8'h01, "R3");
        step(1, 0, 5, 0, 8'h02, "R3");
        step(1, 0, 5, 0, 8'h03, "R3");
        // R4 and R6: store drains three tags while reads are held off.
        step(1, 1, 5, 16'hBEEF, 0, "R4");
        step(1, 0, 7, 0, 8'h09, "R6");
        step(1, 0, 7, 0, 8'h09, "R6");
        step(1, 0, 7, 0, 8'h09, "R6");
        step(0, 3, 0, 0, 0, "R6");
        // R2: hit answered next cycle.
        step(1, 0, 5, 0, 8'h04, "R2");
        // R7: second store refused, value kept.
        step(1, 1, 5, 16'h1234, 0, "R7");
        step(1, 0, 5, 0, 8'h05, "R7");
        // R11: store with nothing pending, then a hit.
        step(1, 1, 9, 16'h0A0A, 0, "R11");
        step(1, 0, 9, 0, 8'h06, "R2");
        // R5: four pending reads, the fifth is stalled.
        for (int i = 0; i < 4; i++) step(1, 0, 20, 0, 8'h10 + i, "R5");
        step(1, 0, 20, 0, 8'h14, "R5");
        step(1, 0, 20, 0, 8'h14, "R5");
        // R9: free refused while pending, then store answers all four.
        step(1, 2, 20, 0, 0, "R9");
        step(1, 1, 20, 16'h5A5A, 0, "R9");
        idle(5, "R9");
        // R8: free then read defers, store answers it.
        step(1, 2, 9, 0, 0, "R8");
        step(1, 0, 9, 0, 8'h20, "R8");
        step(1, 1, 9, 16'h7777, 0, "R8");
        idle(2, "R8");
        // R10: no-op changes neither an empty nor a full word.
        step(1, 3, 30, 16'hFFFF, 8'h30, "R10");
        step(1, 0, 30, 0, 8'h31, "R10");
        step(1, 3, 5, 16'h0000, 8'h32, "R10");
        step(1, 0, 5, 0, 8'h33, "R10");
        step(1, 1, 30, 16'h3030, 0, "R10");
        idle(2, "R10");
        // Boundary addresses, back-to-back traffic.
        step(1, 1, 63, 16'hC0DE, 0, "R11");
        step(1, 0, 0, 0, 8'h40, "R3");
        step(1, 0, 63, 0, 8'h41, "R2");
        step(1, 1, 0, 16'h0101, 0, "R4");
        step(1, 0, 0, 0, 8'h42, "R6");
        step(1, 0, 0, 0, 8'h42, "R2");
        idle(3, "R2");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule